// File: doc/BRIEF.md
# Memory Request Fingerprint Bus Accumulator

This block folds every memory access into one element of the prime field GF(P) by taking a random linear combination of the access fields, and then divides a running bus value by that element. The access fields are the operation label, the context identifier, the address, the clock cycle and four data values. Nine challenge coefficients weight them. The running value and the result are held in the output register `bus_q`. A two-word stream access builds two fingerprints, at `addr` and at `addr+1`, and multiplies them into a single request value before the division. The block does not model the memory itself, and it never judges the final bus value.

Division uses the inverse u^(P-2). This is computed by square-and-multiply, with one modular multiply per cycle on a single shared multiplier. The old bus value is then multiplied by that inverse. The block runs a state machine with six states. `ST_IDLE` accepts a request. A stream request goes from there to `ST_PAIR`, which forms the product. The state then moves between `ST_SQR` (square) and `ST_MULT` (multiply by u) as it walks the exponent bits from the most significant down. `ST_APPLY` writes the bus. `ST_ZERO` handles a request value of zero. Both `ST_APPLY` and `ST_ZERO` return to `ST_IDLE`. The exits from `ST_IDLE` are: a stream request goes to `ST_PAIR`; any other request goes to `ST_SQR`, or to `ST_ZERO` when its fingerprint is zero. `ST_PAIR` goes to `ST_SQR`, or to `ST_ZERO` when the product is zero. `ST_SQR` goes to `ST_MULT` on a set exponent bit, to `ST_APPLY` after bit 0, and otherwise stays in `ST_SQR` with the bit index lowered.

Top module: `fpa_bus_acc`

## Requirements
- R1: After reset, `bus_q` equals `BUS_INIT` and `done`, `err` and `busy` are all 0.
- R2: With `acc_mode` = 0 (word access), the fingerprint is c0 + c1·label + c2·ctx + c3·addr + c4·cyc + c5·s3 + c6·s2 + c7·s1 + c8·s0, reduced mod P. Here sk is field k of `stk` (bits k·W up to k·W+W-1) and ci is field i of `coef`. The value 3 of `acc_mode` behaves the same as 0.
- R3: With `acc_mode` = 1 (single-element access), the four data terms are c5·s0 + c6·h2 + c7·h1 + c8·h0, where hk is field k of `hlp`.
- R4: With `acc_mode` = 2 (stream access), the request value is the product of two fingerprints. Both use the same label, ctx and cyc. The first uses `addr` with data s7, s6, s5, s4 against c5 to c8. The second uses (addr+1) mod P with data s3, s2, s1, s0 against c5 to c8. When `addr` is P-1, the second address wraps to 0.
- R5: The label term is `LBL_WR` when `is_write` is 1 and `LBL_RD` when it is 0. No other field depends on `is_write`.
- R6: For a nonzero request value u, the new bus value b' satisfies b'·u ≡ b (mod P), where b is the value before the request.
- R7: When u ≡ 0, `done` and `err` are high together for one cycle and `bus_q` keeps its value.
- R8: `done` is a one-cycle pulse that appears in the same cycle that `bus_q` takes its new value. `err` is never high without `done`, and `bus_q` never changes while `done` is low.
- R9: `req_valid` is taken only while `busy` is 0. A request presented while the block is busy produces no result and has no effect on `bus_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled in idle only |
| acc_mode | input | 2 | 0 word, 1 single element, 2 two-word stream |
| is_write | input | 1 | Selects the write label instead of the read label |
| ctx | input | W | Context identifier |
| addr | input | W | Access address |
| cyc | input | W | Clock cycle value of the access |
| stk | input | 8·W | Stack entries s0..s7 after the access |
| hlp | input | 3·W | Helper values h0..h2 for single-element access |
| coef | input | 9·W | Challenge coefficients c0..c8 |
| busy | output | 1 | A request is in progress |
| bus_q | output | W | Running bus value |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | Request value was zero (valid with `done`) |

## Verification
The bench builds the block with W = 13 and P = 8191 (2^13−1), and with read and write labels of 5 and 9. This keeps each inverse at 13 exponent bits and about thirty cycles. It also lets the reference compute the inverse by exhaustive search over the whole field, and makes the address wrap at P−1 and the forced zero request cheap to reach. The default 31-bit prime uses the same state sequence and only walks more exponent bits.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    typedef enum logic [1:0] {
        MD_WORD   = 2'd0,
        MD_ELEM   = 2'd1,
        MD_STREAM = 2'd2
    } fpa_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PAIR  = 3'd1,
        ST_SQR   = 3'd2,
        ST_MULT  = 3'd3,
        ST_APPLY = 3'd4,
        ST_ZERO  = 3'd5
    } fpa_state_e;

endpackage

// File: rtl/fpa_modmul.sv
module fpa_modmul #(
    parameter int unsigned     W = 31,
    parameter longint unsigned P = 64'd2147483647
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int unsigned    PW   = 2 * W;
    localparam logic [PW-1:0]  PMOD = PW'(P);

    logic [PW-1:0] prod;

    assign prod = PW'(a) * PW'(b);
    assign y    = W'(prod % PMOD);

endmodule

// File: rtl/fpa_fingerprint.sv
module fpa_fingerprint #(
    parameter int unsigned     W = 31,
    parameter longint unsigned P = 64'd2147483647
) (
    input  logic [9*W-1:0] coef,
    input  logic [W-1:0]   label,
    input  logic [W-1:0]   ctx,
    input  logic [W-1:0]   addr,
    input  logic [W-1:0]   cyc,
    input  logic [4*W-1:0] word,
    output logic [W-1:0]   fp
);
    localparam int unsigned NT = 9;
    localparam int unsigned SW = W + 4;

    logic [NT*W-1:0] opnd;
    logic [NT*W-1:0] term;
    logic [SW-1:0]   sum;

    // term 0 is the constant coefficient, so its operand is one
    assign opnd = {word, cyc, addr, ctx, label, W'(1)};

    for (genvar g = 0; g < NT; g++) begin : g_term
        fpa_modmul #(.W(W), .P(P)) u_mul (
            .a (coef[g*W +: W]),
            .b (opnd[g*W +: W]),
            .y (term[g*W +: W])
        );
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NT; i++) begin
            sum = sum + SW'(term[i*W +: W]);
        end
    end

    assign fp = W'(sum % SW'(P));

endmodule

// File: rtl/fpa_bus_acc.sv
module fpa_bus_acc
    import fpa_pkg::*;
#(
    parameter int unsigned     W        = 31,
    parameter longint unsigned P        = 64'd2147483647,
    parameter longint unsigned LBL_RD   = 64'd1,
    parameter longint unsigned LBL_WR   = 64'd2,
    parameter longint unsigned BUS_INIT = 64'd1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     acc_mode,
    input  logic           is_write,
    input  logic [W-1:0]   ctx,
    input  logic [W-1:0]   addr,
    input  logic [W-1:0]   cyc,
    input  logic [8*W-1:0] stk,
    input  logic [3*W-1:0] hlp,
    input  logic [9*W-1:0] coef,
    output logic           busy,
    output logic [W-1:0]   bus_q,
    output logic           done,
    output logic           err
);
    localparam int unsigned   BW   = (W > 1) ? $clog2(W) : 1;
    localparam int unsigned   PW   = 2 * W;
    localparam logic [W-1:0]  EXPO = W'(P - 2);
    localparam logic [W-1:0]  PM1  = W'(P - 1);
    localparam logic [W-1:0]  ONE  = W'(1);

    fpa_state_e     st_q, st_d;
    logic [BW-1:0]  bit_q;
    logic [W-1:0]   f1_q, f2_q, u_q, acc_q;

    logic [W-1:0]   lbl, addr_nx, fp_a, fp_b, mul_a, mul_b, mul_y;
    logic [4*W-1:0] word_a, word_b;
    logic           is_stream, accept;

    function automatic logic [W-1:0] sk(input int k);
        return stk[k*W +: W];
    endfunction

    function automatic logic [W-1:0] hk(input int k);
        return hlp[k*W +: W];
    endfunction

    // R5: label selects between the two operation labels
    assign lbl       = is_write ? W'(LBL_WR) : W'(LBL_RD);
    // R4: second stream address wraps modulo P
    assign addr_nx   = (addr == PM1) ? '0 : addr + ONE;
    assign is_stream = (acc_mode == MD_STREAM);
    assign accept    = (st_q == ST_IDLE) && req_valid;
    assign busy      = (st_q != ST_IDLE);

    // word field i pairs with coefficient 5+i
    always_comb begin
        word_b = {sk(0), sk(1), sk(2), sk(3)};
        case (acc_mode)
            MD_ELEM:   word_a = {hk(0), hk(1), hk(2), sk(0)};
            MD_STREAM: word_a = {sk(4), sk(5), sk(6), sk(7)};
            default:   word_a = {sk(0), sk(1), sk(2), sk(3)};
        endcase
    end

    fpa_fingerprint #(.W(W), .P(P)) u_fp_a (
        .coef (coef), .label (lbl), .ctx (ctx), .addr (addr),
        .cyc  (cyc),  .word  (word_a), .fp (fp_a)
    );

    fpa_fingerprint #(.W(W), .P(P)) u_fp_b (
        .coef (coef), .label (lbl), .ctx (ctx), .addr (addr_nx),
        .cyc  (cyc),  .word  (word_b), .fp (fp_b)
    );

    // one shared multiplier, operands chosen by state
    always_comb begin
        unique case (st_q)
            ST_PAIR:  begin mul_a = f1_q;  mul_b = f2_q;  end
            ST_SQR:   begin mul_a = acc_q; mul_b = acc_q; end
            ST_MULT:  begin mul_a = acc_q; mul_b = u_q;   end
            ST_APPLY: begin mul_a = bus_q; mul_b = acc_q; end
            default:  begin mul_a = '0;    mul_b = '0;    end
        endcase
    end

    fpa_modmul #(.W(W), .P(P)) u_mul (.a(mul_a), .b(mul_b), .y(mul_y));

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (is_stream)       st_d = ST_PAIR;
                    else if (fp_a == '0) st_d = ST_ZERO;
                    else                 st_d = ST_SQR;
                end
            end
            ST_PAIR:  st_d = (mul_y == '0) ? ST_ZERO : ST_SQR;
            ST_SQR: begin
                if (EXPO[bit_q])        st_d = ST_MULT;
                else if (bit_q == '0)   st_d = ST_APPLY;
            end
            ST_MULT:  st_d = (bit_q == '0) ? ST_APPLY : ST_SQR;
            ST_APPLY: st_d = ST_IDLE;
            ST_ZERO:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            bit_q <= '0;
            f1_q  <= '0;
            f2_q  <= '0;
            u_q   <= '0;
            acc_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                f1_q  <= fp_a;
                f2_q  <= fp_b;
                u_q   <= fp_a;
                acc_q <= ONE;
                bit_q <= BW'(W - 1);
            end
            if (st_q == ST_PAIR) u_q <= mul_y;
            if (st_q == ST_SQR) begin
                acc_q <= mul_y;
                if (!EXPO[bit_q] && bit_q != '0) bit_q <= bit_q - 1'b1;
            end
            if (st_q == ST_MULT) begin
                acc_q <= mul_y;
                if (bit_q != '0) bit_q <= bit_q - 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= W'(BUS_INIT);
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= (st_q == ST_APPLY) || (st_q == ST_ZERO);
            err  <= (st_q == ST_ZERO);
            if (st_q == ST_APPLY) bus_q <= mul_y;
        end
    end

    a_r6_inverse_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_APPLY) |-> (((PW'(acc_q) * PW'(u_q)) % PW'(P)) == PW'(1)));

    a_r7_zero_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> $stable(bus_q));

    a_r8_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(bus_q));

    a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/fpa_bus_acc_test.sv
`timescale 1ns/1ps
module fpa_bus_acc_test;

    localparam int unsigned     W   = 13;
    localparam longint unsigned P   = 64'd8191;
    localparam longint          LRD = 5;
    localparam longint          LWR = 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [1:0]     acc_mode = '0;
    logic           is_write = 1'b0;
    logic [W-1:0]   ctx = '0, addr = '0, cyc = '0;
    logic [8*W-1:0] stk = '0;
    logic [3*W-1:0] hlp = '0;
    logic [9*W-1:0] coef = '0;
    logic           busy, done, err;
    logic [W-1:0]   bus_q;

    always #2 clk = ~clk;

    fpa_bus_acc #(.W(W), .P(P), .LBL_RD(64'd5), .LBL_WR(64'd9), .BUS_INIT(64'd1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_mode(acc_mode),
        .is_write(is_write), .ctx(ctx), .addr(addr), .cyc(cyc), .stk(stk),
        .hlp(hlp), .coef(coef), .busy(busy), .bus_q(bus_q), .done(done), .err(err)
    );

    typedef struct {
        longint bus;
        bit     zero;
        string  tag;
    } exp_t;

    exp_t   sbq[$];
    int     nchk = 0, nerr = 0, ndone = 0, npush = 0;
    longint model_bus = 1;
    bit     prev_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic longint mm(input longint a, input longint b);
        return (a * b) % longint'(P);
    endfunction

    function automatic longint fpm(input longint c[9], input longint lab, input longint cx,
                                   input longint ad, input longint cy, input longint w[4]);
        longint s;
        s = (c[0] + mm(c[1], lab) + mm(c[2], cx) + mm(c[3], ad) + mm(c[4], cy)) % longint'(P);
        for (int i = 0; i < 4; i++) s = (s + mm(c[5+i], w[i])) % longint'(P);
        return s;
    endfunction

    function automatic longint inv(input longint u);
        for (longint x = 1; x < longint'(P); x++) if (mm(u, x) == 1) return x;
        return 0;
    endfunction

    function automatic longint rnd();
        return longint'($urandom % 32'(P));
    endfunction

    // driver: computes the expected result, queues it, then issues the request
    task automatic send(input int md, input bit wr, input longint cx, input longint ad,
                        input longint cy, input longint s[8], input longint h[3],
                        input longint c[9], input bit intrude, input string tag);
        longint w1[4], w2[4], u, lab;
        exp_t e;
        lab = wr ? LWR : LRD;
        if (md == 1) begin
            w1 = '{s[0], h[2], h[1], h[0]};
            u  = fpm(c, lab, cx, ad, cy, w1);
        end else if (md == 2) begin
            w1 = '{s[7], s[6], s[5], s[4]};
            w2 = '{s[3], s[2], s[1], s[0]};
            u  = mm(fpm(c, lab, cx, ad, cy, w1),
                    fpm(c, lab, cx, (ad + 1) % longint'(P), cy, w2));
        end else begin
            w1 = '{s[3], s[2], s[1], s[0]};
            u  = fpm(c, lab, cx, ad, cy, w1);
        end
        if (u == 0) begin
            e.zero = 1'b1;
        end else begin
            e.zero = 1'b0;
            model_bus = mm(model_bus, inv(u));
        end
        e.bus = model_bus;
        e.tag = tag;
        sbq.push_back(e);
        npush++;
        @(negedge clk);
        while (busy) @(negedge clk);
        acc_mode = 2'(md);
        is_write = wr;
        ctx = W'(cx); addr = W'(ad); cyc = W'(cy);
        for (int k = 0; k < 8; k++) stk[k*W +: W] = W'(s[k]);
        for (int k = 0; k < 3; k++) hlp[k*W +: W] = W'(h[k]);
        for (int k = 0; k < 9; k++) coef[k*W +: W] = W'(c[k]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            // R9: a second request while busy must be dropped
            ctx = W'(cx + 17);
            acc_mode = 2'd0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (err && !done) chk(1'b0, "R8 err without done", 1, 0);
            if (done) begin
                ndone++;
                if (prev_done) chk(1'b0, "R8 done longer than one cycle", 1, 0);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9 unexpected result", longint'(bus_q), -1);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(longint'(bus_q) == e.bus, {e.tag, " bus"}, longint'(bus_q), e.bus);
                    chk(err == e.zero, {e.tag, " err R7"}, longint'(err), longint'(e.zero));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        longint s[8], h[3], c[9], cz[9];
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(bus_q == W'(1), "R1 bus", longint'(bus_q), 1);
        chk(done == 1'b0, "R1 done", longint'(done), 0);
        chk(err == 1'b0, "R1 err", longint'(err), 0);
        chk(busy == 1'b0, "R1 busy", longint'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_q == W'(1), "R1 bus after release", longint'(bus_q), 1);

        for (int k = 0; k < 8; k++) s[k] = rnd();
        for (int k = 0; k < 3; k++) h[k] = rnd();
        for (int k = 0; k < 9; k++) c[k] = rnd();

        send(0, 1'b0, 3, 100, 40, s, h, c, 1'b0, "R2 R6 word read");
        send(0, 1'b1, 3, 100, 40, s, h, c, 1'b0, "R5 word write");
        send(1, 1'b0, 4, 200, 41, s, h, c, 1'b0, "R3 element read");
        send(1, 1'b1, 4, 200, 41, s, h, c, 1'b0, "R3 R5 element write");
        send(2, 1'b0, 5, 300, 42, s, h, c, 1'b0, "R4 stream");
        send(2, 1'b0, 5, longint'(P) - 1, 43, s, h, c, 1'b0, "R4 stream address wrap");
        send(3, 1'b0, 6, 10, 44, s, h, c, 1'b0, "R2 mode three as word");

        // R7: all-zero coefficients force u = 0
        for (int k = 0; k < 9; k++) cz[k] = 0;
        send(0, 1'b0, 7, 11, 45, s, h, cz, 1'b0, "R7 zero word");
        // R7: stream whose first fingerprint is zero, second is one
        cz[3] = 1;
        send(2, 1'b1, 7, 0, 46, s, h, cz, 1'b0, "R7 zero stream half");

        // R9: request presented while busy is ignored
        send(0, 1'b1, 8, 500, 47, s, h, c, 1'b1, "R9 busy request dropped");

        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < 8; k++) s[k] = rnd();
            for (int k = 0; k < 3; k++) h[k] = rnd();
            for (int k = 0; k < 9; k++) c[k] = rnd();
            send(n % 3, n[0], rnd(), rnd(), rnd(), s, h, c, 1'b0, "R6 mixed random");
        end

        repeat (20) @(negedge clk);
        chk(ndone == npush, "R9 result count", longint'(ndone), longint'(npush));
        chk(!busy, "R9 idle at end", longint'(busy), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule